// File: doc/BRIEF.md
# ADC Window Comparator Interrupt Unit

This block classifies every new ADC conversion result against a programmable window set by a low and a high threshold. Each accepted result raises a result-loaded flag and exactly one of three window flags (above, below or inside the window) when the thresholds are ordered. Flags are sticky: they hold until software clears them with a per-bit clear strobe. Software can also force any flag with a per-bit set strobe.

The raw flags are ANDed with a mask register to form the masked status. The interrupt line is the OR of the masked flags. A fixed index code names the highest-priority masked source, so a handler can dispatch on a single read without scanning a bit vector. Reading the index has no side effects.

Top module: `adc_wcmp_irq`

## Requirements
- R1: While rst_ni is low and after its release, raw_o, masked_o, irq_idx_o and irq_o are all zero until a result or set strobe arrives.
- R2: A result accepted with res_valid_i high and res_data_i greater than thr_hi_i sets raw_o bit 0 (above-window) on the next rising clock edge.
- R3: A result accepted with res_data_i less than thr_lo_i sets raw_o bit 1 (below-window) on the next rising clock edge.
- R4: A result with thr_lo_i <= res_data_i <= thr_hi_i, boundaries included, sets raw_o bit 2 (in-window) on the next rising clock edge.
- R5: Every accepted result sets raw_o bit 3 (result-loaded), whatever its value.
- R6: Without res_valid_i, res_data_i and the thresholds have no effect on raw_o.
- R7: A raw flag stays set until a clr_i strobe for that bit; the clear takes effect on the next edge and other bits keep their value.
- R8: A clear and a set for the same bit in the same cycle, from either a result hit or set_i, leave the flag set.
- R9: A set_i strobe on a bit sets that raw flag on the next edge.
- R10: masked_o equals raw_o AND mask_i, and irq_o is high exactly when masked_o is non-zero.
- R11: irq_idx_o reports 0x0 when no masked flag is pending, otherwise the lowest code among pending sources: 0x3 above-window (bit 0), 0x4 below-window (bit 1), 0x5 in-window (bit 2), 0x9 result-loaded (bit 3).
- R12: With thr_lo_i greater than thr_hi_i no result sets the in-window flag; a result between the two values sets both the above and below flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| res_valid_i | input | 1 | New conversion result strobe |
| res_data_i | input | 12 | Conversion result |
| thr_lo_i | input | 12 | Window low threshold |
| thr_hi_i | input | 12 | Window high threshold |
| mask_i | input | 4 | Interrupt mask, one bit per source |
| clr_i | input | 4 | Per-flag clear strobes |
| set_i | input | 4 | Per-flag set strobes |
| raw_o | output | 4 | Raw sticky flags |
| masked_o | output | 4 | Raw flags ANDed with mask |
| irq_idx_o | output | 4 | Highest-priority pending source code |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench drives results exactly on both thresholds and one step beyond them, where a strict comparison would report the boundary value as above or below instead of in-window. It clears a flag in the same cycle a new hit or set strobe targets it; a design that lets clear win would drop an event. It sweeps the mask over all sources pending at once to catch a priority encoder that favours the wrong end, and it leaves stale data on the result bus without the strobe to expose a classifier that runs freely. An inverted threshold pair checks that the in-window flag never fires when the window is empty.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;
  parameter int unsigned DATA_W  = 12;
  parameter int unsigned NUM_SRC = 4;
  parameter int unsigned IDX_W   = 4;

  // flag bit positions
  localparam int unsigned SRC_ABOVE  = 0;
  localparam int unsigned SRC_BELOW  = 1;
  localparam int unsigned SRC_INWIN  = 2;
  localparam int unsigned SRC_LOADED = 3;

  localparam logic [IDX_W-1:0] IDX_NONE = 4'h0;

  function automatic logic [IDX_W-1:0] src_code(input int unsigned src);
    case (src)
      SRC_ABOVE:  src_code = 4'h3;
      SRC_BELOW:  src_code = 4'h4;
      SRC_INWIN:  src_code = 4'h5;
      SRC_LOADED: src_code = 4'h9;
      default:    src_code = IDX_NONE;
    endcase
  endfunction
endpackage

// File: rtl/adc_wcmp_classify.sv
module adc_wcmp_classify
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = NUM_SRC
) (
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic [NS-1:0] hit_o
);
  logic gt_hi, lt_lo, ge_lo, le_hi;

  always_comb begin
    gt_hi = data_i > hi_i;
    lt_lo = data_i < lo_i;
    ge_lo = !lt_lo;
    le_hi = !gt_hi;
    hit_o = '0;
    if (valid_i) begin
      hit_o[SRC_ABOVE]  = gt_hi;
      hit_o[SRC_BELOW]  = lt_lo;
      hit_o[SRC_INWIN]  = ge_lo && le_hi;
      hit_o[SRC_LOADED] = 1'b1;
    end
  end
endmodule

// File: rtl/adc_wcmp_flags.sv
module adc_wcmp_flags #(
  parameter int unsigned NS = adc_wcmp_pkg::NUM_SRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] hit_i,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] flag_o
);
  for (genvar g = 0; g < NS; g++) begin : g_flag
    logic q, d;
    // set beats clear
    assign d = hit_i[g] | set_i[g] | (q & ~clr_i[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/adc_wcmp_prio.sv
module adc_wcmp_prio
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned NS = NUM_SRC,
  parameter int unsigned IW = IDX_W
) (
  input  logic [NS-1:0] pend_i,
  output logic [IW-1:0] idx_o
);
  // codes rise with bit position: lowest pending bit wins
  always_comb begin
    idx_o = IDX_NONE;
    for (int i = NS - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = src_code(i);
    end
  end
endmodule

// File: rtl/adc_wcmp_irq.sv
module adc_wcmp_irq
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = NUM_SRC,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_data_i,
  input  logic [DW-1:0] thr_lo_i,
  input  logic [DW-1:0] thr_hi_i,
  input  logic [NS-1:0] mask_i,
  input  logic [NS-1:0] clr_i,
  input  logic [NS-1:0] set_i,
  output logic [NS-1:0] raw_o,
  output logic [NS-1:0] masked_o,
  output logic [IW-1:0] irq_idx_o,
  output logic          irq_o
);
  logic [NS-1:0] hit;

  adc_wcmp_classify #(.DW(DW), .NS(NS)) u_classify (
    .valid_i (res_valid_i),
    .data_i  (res_data_i),
    .lo_i    (thr_lo_i),
    .hi_i    (thr_hi_i),
    .hit_o   (hit)
  );

  adc_wcmp_flags #(.NS(NS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .set_i  (set_i),
    .clr_i  (clr_i),
    .flag_o (raw_o)
  );

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  adc_wcmp_prio #(.NS(NS), .IW(IW)) u_prio (
    .pend_i (masked_o),
    .idx_o  (irq_idx_o)
  );
endmodule

// File: rtl/adc_wcmp_irq_chk.sv
module adc_wcmp_irq_chk
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NS = NUM_SRC,
  parameter int unsigned IW = IDX_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          res_valid_i,
  input logic [DW-1:0] res_data_i,
  input logic [DW-1:0] thr_lo_i,
  input logic [DW-1:0] thr_hi_i,
  input logic [NS-1:0] mask_i,
  input logic [NS-1:0] clr_i,
  input logic [NS-1:0] set_i,
  input logic [NS-1:0] raw_o,
  input logic [NS-1:0] masked_o,
  input logic [IW-1:0] irq_idx_o,
  input logic          irq_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r1: assert (raw_o == '0);
  end

  p_above_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && (res_data_i > thr_hi_i) |=> raw_o[SRC_ABOVE]);

  p_below_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && (res_data_i < thr_lo_i) |=> raw_o[SRC_BELOW]);

  p_inwin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && (res_data_i >= thr_lo_i) && (res_data_i <= thr_hi_i)
    |=> raw_o[SRC_INWIN]);

  p_loaded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> raw_o[SRC_LOADED]);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i && (set_i == '0) && (clr_i == '0) |=> $stable(raw_o));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[SRC_LOADED] && !set_i[SRC_LOADED] && !res_valid_i
    |=> !raw_o[SRC_LOADED]);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[SRC_ABOVE] && set_i[SRC_ABOVE] |=> raw_o[SRC_ABOVE]);

  p_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[SRC_BELOW] |=> raw_o[SRC_BELOW]);

  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_o & mask_i) != '0));

  p_idx_none_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_idx_o != IDX_NONE));

  p_idx_top_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o[SRC_ABOVE] |-> irq_idx_o == src_code(SRC_ABOVE));

  p_empty_win_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_lo_i > thr_hi_i) && !set_i[SRC_INWIN] && !raw_o[SRC_INWIN]
    |=> !raw_o[SRC_INWIN]);
endmodule

bind adc_wcmp_irq adc_wcmp_irq_chk #(.DW(DW), .NS(NS), .IW(IW)) u_chk (.*);

// File: tb/adc_wcmp_irq_tb.sv
module adc_wcmp_irq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [11:0] res_data_i = '0;
  logic [11:0] thr_lo_i = '0;
  logic [11:0] thr_hi_i = '0;
  logic [3:0]  mask_i = '0;
  logic [3:0]  clr_i = '0;
  logic [3:0]  set_i = '0;
  logic [3:0]  raw_o, masked_o, irq_idx_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  adc_wcmp_irq u_dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic apply_result(input logic [11:0] d);
    @(negedge clk_i);
    res_data_i  = d;
    res_valid_i = 1'b1;
    @(negedge clk_i);
    res_valid_i = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] c, input logic [3:0] s);
    @(negedge clk_i);
    clr_i = c; set_i = s;
    @(negedge clk_i);
    clr_i = '0; set_i = '0;
  endtask

  task automatic win(input logic [11:0] lo, input logic [11:0] hi);
    thr_lo_i = lo; thr_hi_i = hi;
    pulse(4'hF, 4'h0);
  endtask

  task automatic t_reset();
    chk("R1 raw in reset", raw_o, 0);
    chk("R1 irq in reset", irq_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    mask_i = 4'hF;
    #1;
    chk("R1 raw after reset", raw_o, 0);
    chk("R1 idx after reset", irq_idx_o, 0);
  endtask

  task automatic t_above();
    win(12'd100, 12'd200);
    apply_result(12'd300);
    chk("R2 above raw", raw_o, 4'b1001);
    chk("R11 above idx", irq_idx_o, 4'h3);
  endtask

  task automatic t_below();
    win(12'd100, 12'd200);
    apply_result(12'd50);
    chk("R3 below raw", raw_o, 4'b1010);
    chk("R11 below idx", irq_idx_o, 4'h4);
  endtask

  task automatic t_inwin();
    win(12'd100, 12'd200);
    apply_result(12'd100);
    chk("R4 low edge raw", raw_o, 4'b1100);
    chk("R11 inwin idx", irq_idx_o, 4'h5);
    win(12'd100, 12'd200);
    apply_result(12'd200);
    chk("R4 high edge raw", raw_o, 4'b1100);
    win(12'd100, 12'd200);
    apply_result(12'd201);
    chk("R4 above edge raw", raw_o, 4'b1001);
    win(12'd100, 12'd200);
    apply_result(12'd99);
    chk("R4 below edge raw", raw_o, 4'b1010);
  endtask

  task automatic t_loaded();
    win(12'd0, 12'hFFF);
    apply_result(12'd0);
    chk("R5 loaded full window", raw_o, 4'b1100);
  endtask

  task automatic t_no_valid();
    win(12'd100, 12'd200);
    @(negedge clk_i); res_data_i = 12'd999;
    @(negedge clk_i); thr_hi_i = 12'd10;
    @(negedge clk_i);
    chk("R6 no strobe raw", raw_o, 0);
    chk("R6 no strobe irq", irq_o, 0);
  endtask

  task automatic t_sticky_clear();
    win(12'd100, 12'd200);
    apply_result(12'd500);
    apply_result(12'd150);
    chk("R7 sticky raw", raw_o, 4'b1101);
    pulse(4'b0001, 4'h0);
    chk("R7 clear one bit", raw_o, 4'b1100);
    chk("R7 idx after clear", irq_idx_o, 4'h5);
  endtask

  task automatic t_clr_set();
    win(12'd100, 12'd200);
    @(negedge clk_i);
    res_data_i = 12'd150; res_valid_i = 1'b1; clr_i = 4'hF;
    @(negedge clk_i);
    res_valid_i = 1'b0; clr_i = '0;
    chk("R8 hit beats clear", raw_o, 4'b1100);
    pulse(4'b0010, 4'b0010);
    chk("R8 set beats clear", raw_o, 4'b1110);
  endtask

  task automatic t_set();
    win(12'd100, 12'd200);
    pulse(4'h0, 4'b0100);
    chk("R9 set strobe", raw_o, 4'b0100);
  endtask

  task automatic t_mask();
    win(12'd100, 12'd200);
    pulse(4'h0, 4'hF);
    mask_i = 4'h0; #1;
    chk("R10 masked none", masked_o, 0);
    chk("R10 irq none", irq_o, 0);
    chk("R11 idx none", irq_idx_o, 0);
    mask_i = 4'b0110; #1;
    chk("R10 masked part", masked_o, 4'b0110);
    chk("R10 irq part", irq_o, 1);
    mask_i = 4'hF;
  endtask

  task automatic t_prio();
    win(12'd100, 12'd200);
    pulse(4'h0, 4'hF);
    mask_i = 4'hF; #1; chk("R11 prio all", irq_idx_o, 4'h3);
    mask_i = 4'hE; #1; chk("R11 prio no above", irq_idx_o, 4'h4);
    mask_i = 4'hC; #1; chk("R11 prio inwin", irq_idx_o, 4'h5);
    mask_i = 4'h8; #1; chk("R11 prio loaded", irq_idx_o, 4'h9);
    mask_i = 4'h5; #1; chk("R11 prio mixed", irq_idx_o, 4'h3);
    @(negedge clk_i);
    chk("R11 index read keeps flags", raw_o, 4'hF);
    mask_i = 4'hF;
  endtask

  task automatic t_empty_win();
    win(12'd200, 12'd100);
    apply_result(12'd150);
    chk("R12 inverted window", raw_o, 4'b1011);
    win(12'd200, 12'd100);
    apply_result(12'd100);
    chk("R12 inverted at hi", raw_o, 4'b1010);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    t_above();
    t_below();
    t_inwin();
    t_loaded();
    t_no_valid();
    t_sticky_clear();
    t_clr_set();
    t_set();
    t_mask();
    t_prio();
    t_empty_win();
    finish_run();
  end
endmodule